// File: doc/BRIEF.md
# Protection Entry Configuration Write Controller

This block holds the configuration bytes and region addresses of a set of physical memory protection entries. It accepts control-register writes and decides, for each entry touched, whether the new value is stored as written, stored in a corrected form, or discarded. The decision depends on the entry's own lock bit, on whether the following entry is a locked top-of-range boundary, and on two machine security inputs. One input lifts all lock checks while a boot loader sets up the table. The other enforces the stricter machine-mode lockdown rules.

A configuration register write spreads its data bytes over several consecutive entries. Every byte is checked on its own, and all the accepted bytes are stored together on one clock edge. An address register write targets exactly one entry. One cycle after each write strobe, a success flag reports whether the register address was a valid target.

Top module: `pmp_csr_ctrl`

## Requirements
- R1: A stored configuration byte keeps only R (bit 0), W (bit 1), X (bit 2), the mode field A (bits 4:3, OFF=0, TOR=1, NA4=2, NAPOT=3) and L (bit 7). Bits 6:5 are always stored as zero.
- R2: A write to configuration register `CFG_BASE+j` covers entries `4*j` through `4*j+XLEN/8-1`. Data byte k goes to entry `4*j+k`, and all accepted bytes are stored on the same clock edge.
- R3: Entries at or above `NUM_ENTRIES` ignore writes. `wr_ok` is high exactly one cycle after a strobe. It is set for a configuration write that covers at least one implemented entry, and for an address write (`ADDR_BASE` to `ADDR_BASE+63`) when `NUM_ENTRIES>0`. Any other strobe, including one to an unrelated register address, leaves it low.
- R4: An address write to entry i is accepted only when entry i is not effectively locked and entry i+1 is not both effectively locked and in TOR mode. An entry is effectively locked when L=1 and `rlb`=0. The last entry skips the next-entry check.
- R5: An accepted address value keeps only its low `PADDR_BITS-2` bits.
- R6: A configuration byte is considered for storage when `rlb`=1, or when the entry has L=0 and the next entry is not effectively locked in TOR mode. These checks use the values held before the write.
- R7: With `mml`=0, a requested R=0,W=1 is stored with W cleared. With `mml`=1 it is stored unchanged.
- R8: When `GRAN_LOG2>2`, a requested mode NA4 is stored as NAPOT.
- R9: With `mml`=1 and `rlb`=0, a corrected byte with L=1 is discarded if X=1, or if W=1 with R=0, unless R, W and X are all 1. A discarded byte leaves the stored byte unchanged.
- R10: After reset, all configuration bytes and addresses are zero and `wr_ok` is low.
- R11: No stored value changes in a cycle without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Control-register write strobe |
| csr_addr | input | 12 | Control-register address |
| csr_wdata | input | XLEN | Write data |
| rlb | input | 1 | Lock bypass: lifts lock and lockdown checks |
| mml | input | 1 | Machine-mode lockdown enable |
| cfg_o | output | 8*max(NUM_ENTRIES,1) | Stored configuration bytes, entry i at bits 8i+7:8i |
| addr_o | output | (PADDR_BITS-2)*max(NUM_ENTRIES,1) | Stored region addresses, entry i in slice i |
| wr_ok | output | 1 | Write success, one cycle after the strobe |

## Verification
The bench first sends one configuration word whose bytes each exercise a different correction: reserved bits set, R=0 with W=1, NA4 under coarse granularity, and a locked TOR boundary. This separates per-byte legalization from byte-to-entry steering. Address writes are then aimed at a locked entry, at the entry just below a locked TOR boundary, and at a free entry, once with the bypass low and once with it high. This separates the entry's own lock check from the next-entry check. A lockdown word with mixed L, X and W patterns tells discarded bytes from accepted ones, including the all-permissions exception. Strobes to an uncovered configuration register and to an unrelated register address show the success flag going low while no stored value changes.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

    localparam int unsigned BIT_R    = 0;
    localparam int unsigned BIT_W    = 1;
    localparam int unsigned BIT_X    = 2;
    localparam int unsigned BIT_A_LO = 3;
    localparam int unsigned BIT_A_HI = 4;
    localparam int unsigned BIT_L    = 7;

    localparam logic [7:0] CFG_KEEP_MASK = 8'h9F;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode #(
    parameter logic [11:0] CFG_BASE  = 12'h3A0,
    parameter logic [11:0] ADDR_BASE = 12'h3B0,
    parameter int unsigned IDX_W     = 8
) (
    input  logic             csr_we,
    input  logic [11:0]      csr_addr,
    output logic             cfg_hit,
    output logic [IDX_W-1:0] cfg_first,
    output logic             addr_hit,
    output logic [5:0]       addr_idx
);
    logic [11:0] cfg_off;
    logic [11:0] addr_off;

    always_comb begin
        cfg_off   = csr_addr - CFG_BASE;
        addr_off  = csr_addr - ADDR_BASE;
        cfg_hit   = csr_we && (csr_addr >= CFG_BASE) && (cfg_off < 12'd16);
        addr_hit  = csr_we && (csr_addr >= ADDR_BASE) && (addr_off < 12'd64);
        cfg_first = '0;
        cfg_first[5:0] = {cfg_off[3:0], 2'b00};
        addr_idx  = addr_off[5:0];
    end
endmodule

// File: rtl/pmp_lock_view.sv
module pmp_lock_view #(
    parameter int unsigned NE = 8
) (
    input  logic [NE-1:0][7:0] cfg,
    input  logic               rlb,
    output logic [NE-1:0]      eff_lock,
    output logic [NE-1:0]      next_tor_lock
);
    import pmp_csr_pkg::*;

    for (genvar i = 0; i < NE; i++) begin : g_lock
        assign eff_lock[i] = cfg[i][BIT_L] && !rlb;
        if (i == NE - 1) begin : g_last
            assign next_tor_lock[i] = 1'b0;
        end else begin : g_mid
            assign next_tor_lock[i] = cfg[i+1][BIT_L] && !rlb &&
                (cfg[i+1][BIT_A_HI:BIT_A_LO] == MODE_TOR);
        end
    end
endmodule

// File: rtl/pmp_cfg_legalize.sv
module pmp_cfg_legalize #(
    parameter int unsigned GRAN_LOG2 = 2
) (
    input  logic [7:0] raw,
    input  logic       rlb,
    input  logic       mml,
    output logic [7:0] cfg,
    output logic       drop
);
    import pmp_csr_pkg::*;

    localparam bit COARSE = (GRAN_LOG2 > 2);

    logic exec_or_wonly;
    logic all_rwx;

    always_comb begin
        cfg = raw & CFG_KEEP_MASK;
        if (!mml && !cfg[BIT_R]) begin
            cfg[BIT_W] = 1'b0;
        end
        if (COARSE && (cfg[BIT_A_HI:BIT_A_LO] == MODE_NA4)) begin
            cfg[BIT_A_HI:BIT_A_LO] = MODE_NAPOT;
        end
        all_rwx       = cfg[BIT_R] && cfg[BIT_W] && cfg[BIT_X];
        exec_or_wonly = cfg[BIT_X] || (cfg[BIT_W] && !cfg[BIT_R]);
        drop = !rlb && mml && cfg[BIT_L] && !all_rwx && exec_or_wonly;
    end
endmodule

// File: rtl/pmp_csr_ctrl.sv
module pmp_csr_ctrl #(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned XLEN        = 32,
    parameter int unsigned GRAN_LOG2   = 2,
    parameter int unsigned PADDR_BITS  = 34,
    parameter logic [11:0] CFG_BASE    = 12'h3A0,
    parameter logic [11:0] ADDR_BASE   = 12'h3B0,
    localparam int unsigned NE_EFF     = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1,
    localparam int unsigned ADDR_W     = PADDR_BITS - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csr_we,
    input  logic [11:0]              csr_addr,
    input  logic [XLEN-1:0]          csr_wdata,
    input  logic                     rlb,
    input  logic                     mml,
    output logic [NE_EFF*8-1:0]      cfg_o,
    output logic [NE_EFF*ADDR_W-1:0] addr_o,
    output logic                     wr_ok
);
    import pmp_csr_pkg::*;

    localparam int unsigned BPW   = XLEN / 8;
    localparam int unsigned KW    = (BPW > 1) ? $clog2(BPW) : 1;
    localparam int unsigned IDX_W = 8;

    typedef struct packed {
        logic [NE_EFF-1:0][7:0]        cfg;
        logic [NE_EFF-1:0][ADDR_W-1:0] addr;
        logic                          ok;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             cfg_hit;
    logic [IDX_W-1:0] cfg_first;
    logic             addr_hit;
    logic [5:0]       addr_idx;

    logic [NE_EFF-1:0]      eff_lock;
    logic [NE_EFF-1:0]      next_tor_lock;
    logic [NE_EFF-1:0]      byte_hit;
    logic [NE_EFF-1:0][7:0] raw_byte;
    logic [NE_EFF-1:0][7:0] leg_byte;
    logic [NE_EFF-1:0]      leg_drop;
    logic [ADDR_W-1:0]      addr_val;

    pmp_csr_decode #(
        .CFG_BASE (CFG_BASE),
        .ADDR_BASE(ADDR_BASE),
        .IDX_W    (IDX_W)
    ) u_decode (
        .csr_we   (csr_we),
        .csr_addr (csr_addr),
        .cfg_hit  (cfg_hit),
        .cfg_first(cfg_first),
        .addr_hit (addr_hit),
        .addr_idx (addr_idx)
    );

    pmp_lock_view #(
        .NE(NE_EFF)
    ) u_lock (
        .cfg          (st_q.cfg),
        .rlb          (rlb),
        .eff_lock     (eff_lock),
        .next_tor_lock(next_tor_lock)
    );

    if (XLEN >= ADDR_W) begin : g_addr_trunc
        assign addr_val = csr_wdata[ADDR_W-1:0];
    end else begin : g_addr_ext
        assign addr_val = {{(ADDR_W - XLEN){1'b0}}, csr_wdata};
    end

    for (genvar i = 0; i < NE_EFF; i++) begin : g_entry
        logic [KW-1:0] lane;
        int            rel;

        always_comb begin
            rel         = i - int'(cfg_first);
            byte_hit[i] = cfg_hit && (rel >= 0) && (rel < int'(BPW)) &&
                          (i < NUM_ENTRIES);
            lane        = rel[KW-1:0];
            raw_byte[i] = csr_wdata[lane*8 +: 8];
        end

        pmp_cfg_legalize #(
            .GRAN_LOG2(GRAN_LOG2)
        ) u_legal (
            .raw (raw_byte[i]),
            .rlb (rlb),
            .mml (mml),
            .cfg (leg_byte[i]),
            .drop(leg_drop[i])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.ok = (cfg_hit && (|byte_hit)) || (addr_hit && (NUM_ENTRIES > 0));
        for (int i = 0; i < NE_EFF; i++) begin
            if (byte_hit[i] && !leg_drop[i] &&
                (rlb || (!st_q.cfg[i][BIT_L] && !next_tor_lock[i]))) begin
                st_d.cfg[i] = leg_byte[i];
            end
            if (addr_hit && (int'(addr_idx) == i) && (i < NUM_ENTRIES) &&
                !eff_lock[i] && !next_tor_lock[i]) begin
                st_d.addr[i] = addr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign addr_o = st_q.addr;
    assign wr_ok  = st_q.ok;

endmodule

// File: rtl/pmp_csr_ctrl_chk.sv
module pmp_csr_ctrl_chk #(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned GRAN_LOG2   = 2,
    localparam int unsigned NE_EFF     = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     csr_we,
    input logic                     rlb,
    input logic                     mml,
    input logic [NE_EFF*8-1:0]      cfg_o,
    input logic [NE_EFF*ADDR_W-1:0] addr_o,
    input logic                     wr_ok
);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ($stable(cfg_o) && $stable(addr_o)));

    // R3
    idle_no_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> !wr_ok);

    for (genvar i = 0; i < NE_EFF; i++) begin : g_chk
        // R1
        rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_o[i*8+5 +: 2] == 2'b00);

        // R4
        locked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_o[i*8+7] && !rlb) |=> $stable(addr_o[i*ADDR_W +: ADDR_W]));

        // R6
        locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_o[i*8+7] && !rlb) |=> $stable(cfg_o[i*8 +: 8]));

        // R7
        no_wonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mml |=> ($stable(cfg_o[i*8 +: 8]) ||
                      !(cfg_o[i*8+1] && !cfg_o[i*8])));

        if (GRAN_LOG2 > 2) begin : g_coarse
            // R8
            no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
                csr_we |=> ($stable(cfg_o[i*8 +: 8]) ||
                            (cfg_o[i*8+3 +: 2] != 2'd2)));
        end
    end
endmodule

bind pmp_csr_ctrl pmp_csr_ctrl_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W),
    .GRAN_LOG2  (GRAN_LOG2)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .csr_we(csr_we),
    .rlb   (rlb),
    .mml   (mml),
    .cfg_o (cfg_o),
    .addr_o(addr_o),
    .wr_ok (wr_ok)
);

// File: tb/pmp_csr_ctrl_bench.sv
module pmp_csr_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NE   = 6;
    localparam int XL   = 64;
    localparam int AW   = 32;

    typedef struct packed {
        logic        we;
        logic        rlb;
        logic        mml;
        logic [11:0] csr;
        logic [63:0] wd;
        logic        is_addr;
        logic [2:0]  idx;
        logic [31:0] exp;
        logic        ok;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // R5: upper data bits dropped
        '{1'b1, 1'b0, 1'b0, 12'h3B0, 64'hFFFF_FFFF_1234_5678, 1'b1, 3'd0, 32'h1234_5678, 1'b1, 4'd5},
        // R1: reserved bits cleared on entry 0
        '{1'b1, 1'b0, 1'b0, 12'h3A0, 64'hAAAA_0301_8910_0267, 1'b0, 3'd0, 32'h07, 1'b1, 4'd1},
        // R7: R=0 W=1 cleared without lockdown
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd1, 32'h00, 1'b0, 4'd7},
        // R8: NA4 turned into NAPOT
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd2, 32'h18, 1'b0, 4'd8},
        // R2: byte 3 steered to entry 3
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd3, 32'h89, 1'b0, 4'd2},
        // R2
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd4, 32'h01, 1'b0, 4'd2},
        // R2
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd5, 32'h03, 1'b0, 4'd2},
        // R4: next entry is locked TOR
        '{1'b1, 1'b0, 1'b0, 12'h3B2, 64'h22, 1'b1, 3'd2, 32'h0, 1'b1, 4'd4},
        // R4: own entry locked
        '{1'b1, 1'b0, 1'b0, 12'h3B3, 64'h33, 1'b1, 3'd3, 32'h0, 1'b1, 4'd4},
        // R4: free entry accepted
        '{1'b1, 1'b0, 1'b0, 12'h3B4, 64'h44, 1'b1, 3'd4, 32'h44, 1'b1, 4'd4},
        // R6: entry below locked TOR keeps its byte
        '{1'b1, 1'b0, 1'b0, 12'h3A0, 64'h0, 1'b0, 3'd2, 32'h18, 1'b1, 4'd6},
        // R6: locked entry keeps its byte
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd3, 32'h89, 1'b0, 4'd6},
        // R6: unlocked entry cleared
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd0, 32'h00, 1'b0, 4'd6},
        // R4: bypass lifts next-entry check
        '{1'b1, 1'b1, 1'b0, 12'h3B2, 64'h22, 1'b1, 3'd2, 32'h22, 1'b1, 4'd4},
        // R6: bypass unlocks config write
        '{1'b1, 1'b1, 1'b0, 12'h3A0, 64'h0, 1'b0, 3'd3, 32'h00, 1'b1, 4'd6},
        // R6
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd2, 32'h00, 1'b0, 4'd6},
        // R3: register covering entries 8..15, none implemented
        '{1'b1, 1'b0, 1'b0, 12'h3A2, 64'hFF, 1'b0, 3'd0, 32'h00, 1'b0, 4'd3},
        // R3: unrelated register address
        '{1'b1, 1'b0, 1'b0, 12'h300, 64'h5, 1'b1, 3'd0, 32'h1234_5678, 1'b0, 4'd3},
        // R9: locked W-only discarded
        '{1'b1, 1'b0, 1'b1, 12'h3A0, 64'h0000_0C81_0287_8482, 1'b0, 3'd0, 32'h00, 1'b1, 4'd9},
        // R9: locked X discarded
        '{1'b0, 1'b0, 1'b1, 12'h000, 64'h0, 1'b0, 3'd1, 32'h00, 1'b0, 4'd9},
        // R9: locked RWX allowed
        '{1'b0, 1'b0, 1'b1, 12'h000, 64'h0, 1'b0, 3'd2, 32'h87, 1'b0, 4'd9},
        // R7: W-only kept under lockdown
        '{1'b0, 1'b0, 1'b1, 12'h000, 64'h0, 1'b0, 3'd3, 32'h02, 1'b0, 4'd7},
        // R9: locked read-only allowed
        '{1'b0, 1'b0, 1'b1, 12'h000, 64'h0, 1'b0, 3'd4, 32'h81, 1'b0, 4'd9},
        // R9: unlocked X allowed
        '{1'b0, 1'b0, 1'b1, 12'h000, 64'h0, 1'b0, 3'd5, 32'h0C, 1'b0, 4'd9},
        // R9: bypass lets locked X through
        '{1'b1, 1'b1, 1'b1, 12'h3A0, 64'h84, 1'b0, 3'd0, 32'h84, 1'b1, 4'd9},
        // R9: bypass rewrites locked entry
        '{1'b0, 1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 3'd2, 32'h00, 1'b0, 4'd9}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             csr_we;
    logic [11:0]      csr_addr;
    logic [XL-1:0]    csr_wdata;
    logic             rlb;
    logic             mml;
    logic [NE*8-1:0]  cfg_o;
    logic [NE*AW-1:0] addr_o;
    logic             wr_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmp_csr_ctrl #(
        .NUM_ENTRIES(NE),
        .XLEN       (XL),
        .GRAN_LOG2  (3),
        .PADDR_BITS (34)
    ) u_pmp_csr_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_we   (csr_we),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .rlb      (rlb),
        .mml      (mml),
        .cfg_o    (cfg_o),
        .addr_o   (addr_o),
        .wr_ok    (wr_ok)
    );

    task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp,
                         input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all_zero(input int req);
        for (int e = 0; e < NE; e++) begin
            check(req, {56'h0, cfg_o[e*8 +: 8]}, 64'h0, "reset cfg");
            check(req, {32'h0, addr_o[e*AW +: AW]}, 64'h0, "reset addr");
        end
        check(req, {63'h0, wr_ok}, 64'h0, "reset ok");
    endtask

    initial begin
        rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0; rlb = 1'b0; mml = 1'b0;
        repeat (3) @(negedge clk);
        // R10: state after reset
        check_all_zero(10);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            csr_we    = VECS[v].we;
            rlb       = VECS[v].rlb;
            mml       = VECS[v].mml;
            csr_addr  = VECS[v].csr;
            csr_wdata = VECS[v].wd;
            @(negedge clk);
            if (VECS[v].is_addr)
                check(int'(VECS[v].req), {32'h0, addr_o[VECS[v].idx*AW +: AW]},
                      {32'h0, VECS[v].exp}, "addr");
            else
                check(int'(VECS[v].req), {56'h0, cfg_o[VECS[v].idx*8 +: 8]},
                      {32'h0, VECS[v].exp}, "cfg");
            // R3: success flag one cycle after strobe
            check(3, {63'h0, wr_ok}, {63'h0, VECS[v].ok}, "wr_ok");
        end

        // R11: idle cycles change nothing
        csr_we = 1'b0; rlb = 1'b1; csr_addr = 12'h3A0; csr_wdata = '1;
        repeat (2) @(negedge clk);
        check(11, {56'h0, cfg_o[0 +: 8]}, 64'h84, "idle cfg");
        check(11, {32'h0, addr_o[4*AW +: AW]}, 64'h44, "idle addr");

        // R10: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check_all_zero(10);
        rst_n = 1'b1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule